// File: doc/BRIEF.md
# Maskable Interrupt Status Register Bank

This block collects single-cycle event pulses from a small peripheral into latched status bits and drives one level interrupt toward a host. A main register holds seven latched event bits and one summary bit. An auxiliary register holds four more event bits: timer 1 expiry, timer 2 expiry, watchdog overflow and external wake. Each register has a mask register. A mask bit of 1 hides its source, and a mask bit of 0 lets it through.

A masked event is not lost. It reads as 0 while masked but stays latched, and it shows up as soon as the mask bit is cleared. The channel-change event is the one exception. Its status bit is always visible, but it raises the interrupt line only while it is unmasked.

The host uses a plain strobe port with an address, write data, a read strobe and a write strobe. Reading a status register clears the bits that the read returned as 1. Read data appears one clock after the strobe.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, both mask registers are all ones, every latched bit is 0 and `irq_o` is low. Events that arrive while every mask bit is 1 leave `irq_o` low and read back as 0.
- R2: A write to address 0x60 loads the main mask from `wr_data_i`, and a write to 0x61 loads the auxiliary mask from `wr_data_i[3:0]`. A mask bit of 0 enables its source and a 1 disables it.
- R3: A pulse on `main_evt_i[k]` latches main status bit k+1. A read strobe at address 0x60 returns the visible main status on `rd_data_o` one clock later, and `rd_data_o` holds its value while no read is strobed.
- R4: A masked main bit reads as 0 and stays pending, including across reads. After its mask bit is cleared, it reads as 1.
- R5: The channel-change bit (main bit 1, from `main_evt_i[0]`) reads as 1 whenever it is latched, even if it is masked. A masked channel change never asserts `irq_o`.
- R6: A read at 0x61 returns the visible auxiliary status: bit 0 is timer 1, bit 1 is timer 2, bit 2 is watchdog overflow and bit 3 is external wake. Bits 7:4 read as 0.
- R7: Main bit 0 is the OR of the unmasked auxiliary bits, gated by main mask bit 0. A main read does not clear it. It falls only when those auxiliary bits are cleared by an auxiliary read.
- R8: A status read clears exactly the bits it returned as 1. An event that arrives in the same cycle as the read stays latched for the next read.
- R9: `irq_o` is high exactly when some latched bit is unmasked. It changes on the same clock edge that latches the event, clears the bit or writes the mask.
- R10: A read at any other address returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wr_i | input | 1 | Write strobe |
| main_evt_i | input | 7 | Main event pulses; bit k sets status bit k+1 |
| aux_evt_i | input | 4 | Auxiliary pulses: timer 1, timer 2, watchdog, wake |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The directed phase uses three kinds of pattern.

- Events that arrive while masked and are unmasked later. These separate "hidden but pending" from "dropped" or "shown".
- A masked channel change. This separates status visibility from interrupt generation.
- An event on a bit in the same cycle as a read of that bit. This tells clear-exactly-what-was-returned apart from a blanket clear.

Auxiliary events are read through both registers, which shows that the summary bit follows the auxiliary state rather than main reads. A long pseudo-random phase then mixes sparse pulses, mask writes and reads at the valid addresses and at a stray address. A behavioural model follows every clock of that phase.

// File: rtl/irqbank_pkg.sv
// Package: shared constants and the register-select type for the
// interrupt status bank. Assumes an 8-bit host address space.
package irqbank_pkg;

    // Register addresses on the host port.
    localparam logic [7:0] MAIN_REG_ADDR = 8'h60;
    localparam logic [7:0] AUX_REG_ADDR  = 8'h61;

    // Fixed bit positions inside the main register (neighbours decode them).
    localparam int SUM_BIT = 0;   // auxiliary summary
    localparam int CHG_BIT = 1;   // channel change, always visible

    // Which register an access addresses.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MAIN = 2'd1,
        SEL_AUX  = 2'd2
    } reg_sel_t;

endpackage

// File: rtl/irqbank_decode.sv
// Module: irqbank_decode
// Turns the host address and strobes into per-register read and write
// enables. Assumes the strobes are already synchronous to clk.
module irqbank_decode #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  MAIN_ADDR = irqbank_pkg::MAIN_REG_ADDR,
    parameter logic [7:0]  AUX_ADDR  = irqbank_pkg::AUX_REG_ADDR
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output irqbank_pkg::reg_sel_t sel_o,
    output logic              main_rd_o,
    output logic              main_wr_o,
    output logic              aux_rd_o,
    output logic              aux_wr_o
);
    import irqbank_pkg::*;

    localparam logic [ADDR_W-1:0] MAIN_A = ADDR_W'(MAIN_ADDR);
    localparam logic [ADDR_W-1:0] AUX_A  = ADDR_W'(AUX_ADDR);

    // Address match to register select.
    always_comb begin
        if (addr_i == MAIN_A)      sel_o = SEL_MAIN;
        else if (addr_i == AUX_A)  sel_o = SEL_AUX;
        else                       sel_o = SEL_NONE;
    end

    // Qualify strobes with the select.
    always_comb begin
        main_rd_o = rd_i && (sel_o == SEL_MAIN);
        main_wr_o = wr_i && (sel_o == SEL_MAIN);
        aux_rd_o  = rd_i && (sel_o == SEL_AUX);
        aux_wr_o  = wr_i && (sel_o == SEL_AUX);
    end

endmodule

// File: rtl/irqbank_srcbank.sv
// Module: irqbank_srcbank
// One group of latched event bits with its mask. Events are single-cycle
// pulses. A read clears only the visible bits; bits flagged in ALWAYS_VIS
// stay visible while masked. Reset is synchronous, active low.
module irqbank_srcbank #(
    parameter int           W          = 4,
    parameter logic [W-1:0] ALWAYS_VIS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_d_i,
    output logic [W-1:0] vis_o,
    output logic         act_nxt_o
);
    logic [W-1:0] lat_q, lat_d;
    logic [W-1:0] mask_q, mask_d;

    // Visible bits: unmasked, or flagged as always shown.
    assign vis_o = lat_q & (~mask_q | ALWAYS_VIS);

    // Per-bit next-state: clear what the read returned, then add new events.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            lat_d[b] = (lat_q[b] & ~(rd_clr_i & vis_o[b])) | evt_i[b];
        end
    end

    // Mask next-state from host write.
    assign mask_d = mask_wr_i ? mask_d_i : mask_q;

    // Any source that will be latched and unmasked after this edge.
    assign act_nxt_o = |(lat_d & ~mask_d);

    // State registers; masks reset disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            mask_q <= '1;
        end else begin
            lat_q  <= lat_d;
            mask_q <= mask_d;
        end
    end

    // R3: every pulsed event is latched on the next edge.
    a_r3_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((lat_q & $past(evt_i)) == $past(evt_i)));

    // R8: with no read, no latched bit is lost.
    a_r8_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

    // R4: masked, hidden bits survive a read.
    a_r4_masked_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr_i |=> ((lat_q & $past(lat_q & mask_q & ~ALWAYS_VIS))
                      == $past(lat_q & mask_q & ~ALWAYS_VIS)));

endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank (top)
// Main and auxiliary interrupt status registers with masks, clear-on-read
// host access and one level interrupt. Main bit 0 summarises unmasked
// auxiliary bits; main bit 1 (channel change) is always visible.
// Assumes single-cycle event pulses and one-cycle read strobes.
module irq_status_bank #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter int          AUX_W     = 4,
    parameter logic [7:0]  MAIN_ADDR = irqbank_pkg::MAIN_REG_ADDR,
    parameter logic [7:0]  AUX_ADDR  = irqbank_pkg::AUX_REG_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-2:0] main_evt_i,
    input  logic [AUX_W-1:0]  aux_evt_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import irqbank_pkg::*;

    localparam int MAIN_EW = DATA_W - 1;
    localparam logic [MAIN_EW-1:0] MAIN_ALWAYS =
        MAIN_EW'(1) << (CHG_BIT - 1);

    reg_sel_t            sel;
    logic                main_rd, main_wr, aux_rd, aux_wr;
    logic [MAIN_EW-1:0]  main_vis;
    logic [AUX_W-1:0]    aux_vis;
    logic                main_act_nxt, aux_act_nxt;
    logic                sum_mask_q, sum_mask_d;
    logic                sum_vis;
    logic [DATA_W-1:0]   main_word, aux_word;
    logic [DATA_W-1:0]   rdata_q;
    logic                irq_q;

    irqbank_decode #(
        .ADDR_W(ADDR_W), .MAIN_ADDR(MAIN_ADDR), .AUX_ADDR(AUX_ADDR)
    ) u_dec (
        .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .sel_o(sel),
        .main_rd_o(main_rd), .main_wr_o(main_wr),
        .aux_rd_o(aux_rd), .aux_wr_o(aux_wr)
    );

    irqbank_srcbank #(.W(MAIN_EW), .ALWAYS_VIS(MAIN_ALWAYS)) u_main (
        .clk(clk), .rst_n(rst_n), .evt_i(main_evt_i),
        .rd_clr_i(main_rd), .mask_wr_i(main_wr),
        .mask_d_i(wr_data_i[DATA_W-1:1]),
        .vis_o(main_vis), .act_nxt_o(main_act_nxt)
    );

    irqbank_srcbank #(.W(AUX_W), .ALWAYS_VIS('0)) u_aux (
        .clk(clk), .rst_n(rst_n), .evt_i(aux_evt_i),
        .rd_clr_i(aux_rd), .mask_wr_i(aux_wr),
        .mask_d_i(wr_data_i[AUX_W-1:0]),
        .vis_o(aux_vis), .act_nxt_o(aux_act_nxt)
    );

    // Summary mask bit lives beside the main bank's mask.
    assign sum_mask_d = main_wr ? wr_data_i[SUM_BIT] : sum_mask_q;

    // Summary bit as shown in the main register.
    assign sum_vis = (|aux_vis) & ~sum_mask_q;

    // Assemble the readable words.
    assign main_word = {main_vis, sum_vis};
    assign aux_word  = {{(DATA_W-AUX_W){1'b0}}, aux_vis};

    // Summary mask, read data and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_mask_q <= 1'b1;
            rdata_q    <= '0;
            irq_q      <= 1'b0;
        end else begin
            sum_mask_q <= sum_mask_d;
            if (rd_i) begin
                case (sel)
                    SEL_MAIN: rdata_q <= main_word;
                    SEL_AUX:  rdata_q <= aux_word;
                    default:  rdata_q <= '0;
                endcase
            end
            irq_q <= main_act_nxt | (aux_act_nxt & ~sum_mask_d);
        end
    end

    assign rd_data_o = rdata_q;
    assign irq_o     = irq_q;

    // R1: interrupt is low on the first cycle after reset.
    a_r1_irq_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq_o);

    // R3: read data holds while no read is strobed.
    a_r3_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

    // R7: a main read never drops the auxiliary pending state.
    a_r7_sum_survives_main_read: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rd && (|aux_vis) && !aux_wr) |=> (|aux_vis));

    // R10: strobes never address both registers.
    a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_rd, aux_rd}));

endmodule

// File: tb/irq_status_bank_test.sv
module irq_status_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [6:0] main_evt_i = '0;
    logic [3:0] aux_evt_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // Behavioural reference state.
    bit [7:0] m_lat, m_msk, exp_rd;
    bit [3:0] a_lat, a_msk;
    bit       exp_irq;
    bit       last_aux_read;
    bit [31:0] seed = 32'h1234_5678;

    irq_status_bank uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_data_i(wr_data_i),
        .rd_i(rd_i), .wr_i(wr_i), .main_evt_i(main_evt_i),
        .aux_evt_i(aux_evt_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] expv);
        vectors++;
        if (got !== expv) begin
            misses++;
            $display("FAIL %s got %02h expected %02h at %0t", tag, got, expv, $time);
        end
    endtask

    // Reference model update at a rising edge.
    task automatic model_edge();
        bit [7:0] vm;
        bit [3:0] va;
        bit       sumv;
        if (!rst_n) begin
            m_lat = 0; a_lat = 0; m_msk = 8'hFF; a_msk = 4'hF;
            exp_rd = 0; exp_irq = 0;
            return;
        end
        va   = a_lat & ~a_msk;
        sumv = (|va) & ~m_msk[0];
        vm   = (m_lat & ~m_msk & 8'hFE) | (m_lat & 8'h02) | {7'b0, sumv};
        if (rd_i) begin
            if (addr_i == 8'h60) begin
                exp_rd = vm; m_lat = m_lat & ~vm; last_aux_read = 0;
            end else if (addr_i == 8'h61) begin
                exp_rd = {4'h0, va}; a_lat = a_lat & ~va; last_aux_read = 1;
            end else begin
                exp_rd = 0;
            end
        end
        m_lat = m_lat | {main_evt_i, 1'b0};
        a_lat = a_lat | aux_evt_i;
        if (wr_i && addr_i == 8'h60) m_msk = wr_data_i;
        if (wr_i && addr_i == 8'h61) a_msk = wr_data_i[3:0];
        exp_irq = (|(m_lat[7:1] & ~m_msk[7:1])) | ((|(a_lat & ~a_msk)) & ~m_msk[0]);
    endtask

    // One clock: model at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R9 irq", {7'b0, irq_o}, {7'b0, exp_irq});
        chk(last_aux_read ? "R6 rdata" : "R3 rdata", rd_data_o, exp_rd);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr_i = a; wr_data_i = d; wr_i = 1; step(); wr_i = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        addr_i = a; rd_i = 1; step(); rd_i = 0;
    endtask

    task automatic pm(input logic [6:0] v);
        main_evt_i = v; step(); main_evt_i = '0;
    endtask

    task automatic pa(input logic [3:0] v);
        aux_evt_i = v; step(); aux_evt_i = '0;
    endtask

    function automatic bit [31:0] nxt(input bit [31:0] s);
        bit [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: reset state
        chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
        rd(8'h60); chk("R1 main status", rd_data_o, 8'h00);
        rd(8'h61); chk("R1 aux status", rd_data_o, 8'h00);
        pa(4'hF);  chk("R1 masked aux irq", {7'b0, irq_o}, 8'h00);
        rd(8'h61); chk("R1 masked aux read", rd_data_o, 8'h00);
        wr(8'h61, 8'h00);
        rd(8'h61); chk("R2 pending aux after unmask", rd_data_o, 8'h0F);
        wr(8'h61, 8'hFF);
        // R4: masked event pending, shows after unmask
        pm(7'h10); chk("R4 masked irq", {7'b0, irq_o}, 8'h00);
        rd(8'h60); chk("R4 masked read", rd_data_o, 8'h00);
        wr(8'h60, 8'hDF); chk("R9 irq on unmask", {7'b0, irq_o}, 8'h01);
        rd(8'h60); chk("R4 visible after unmask", rd_data_o, 8'h20);
        chk("R8 irq drops after read", {7'b0, irq_o}, 8'h00);
        rd(8'h60); chk("R8 cleared", rd_data_o, 8'h00);
        // R5: channel change visible while masked, no interrupt
        wr(8'h60, 8'hFF);
        pm(7'h01); chk("R5 masked chg irq", {7'b0, irq_o}, 8'h00);
        rd(8'h60); chk("R5 chg visible", rd_data_o, 8'h02);
        rd(8'h60); chk("R8 chg cleared", rd_data_o, 8'h00);
        // R7 / R6: summary and aux register
        wr(8'h61, 8'hF0);
        pa(4'h2);
        rd(8'h60); chk("R7 summary masked", rd_data_o, 8'h00);
        chk("R7 summary masked irq", {7'b0, irq_o}, 8'h00);
        wr(8'h60, 8'hFE); chk("R7 summary irq", {7'b0, irq_o}, 8'h01);
        rd(8'h60); chk("R7 summary shown", rd_data_o, 8'h01);
        rd(8'h60); chk("R7 summary not cleared", rd_data_o, 8'h01);
        rd(8'h61); chk("R6 timer2 bit", rd_data_o, 8'h02);
        chk("R9 irq after aux read", {7'b0, irq_o}, 8'h00);
        rd(8'h60); chk("R7 summary gone", rd_data_o, 8'h00);
        pa(4'h8); rd(8'h61); chk("R6 wake bit", rd_data_o, 8'h08);
        pa(4'h4); rd(8'h61); chk("R6 watchdog bit", rd_data_o, 8'h04);
        pa(4'h1); rd(8'h61); chk("R6 timer1 bit", rd_data_o, 8'h01);
        // R8: event in the same cycle as the read
        wr(8'h60, 8'hF7);
        pm(7'h04);
        addr_i = 8'h60; rd_i = 1; main_evt_i = 7'h04; step();
        rd_i = 0; main_evt_i = '0;
        chk("R8 first read", rd_data_o, 8'h08);
        rd(8'h60); chk("R8 same-cycle event kept", rd_data_o, 8'h08);
        rd(8'h60); chk("R8 then clear", rd_data_o, 8'h00);
        // R10: stray address
        pm(7'h04);
        rd(8'h10); chk("R10 stray read", rd_data_o, 8'h00);
        rd(8'h60); chk("R10 nothing cleared", rd_data_o, 8'h08);
        // R2: aux mask enable/disable
        wr(8'h61, 8'hFF); pa(4'h1);
        rd(8'h61); chk("R2 aux masked", rd_data_o, 8'h00);
        wr(8'h61, 8'h00);
        rd(8'h61); chk("R2 aux enabled", rd_data_o, 8'h01);
        // Pseudo-random phase, compared every clock.
        for (int i = 0; i < 4000; i++) begin
            seed = nxt(seed);
            main_evt_i = (seed[3:0] == 0) ? seed[10:4] : '0;
            aux_evt_i  = (seed[7:5] == 0) ? seed[14:11] : '0;
            rd_i = (seed[17:16] == 0);
            wr_i = !rd_i && (seed[22:19] == 0);
            case (seed[25:24])
                2'd0: addr_i = 8'h10;
                2'd1: addr_i = 8'h61;
                default: addr_i = 8'h60;
            endcase
            wr_data_i = seed[31:24] ^ seed[15:8];
            step();
        end
        main_evt_i = '0; aux_evt_i = '0; rd_i = 0; wr_i = 0;
        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule